// File: doc/BRIEF.md
# Raster Logic Write Unit with Dual Write Masks

This block is the write data path of a narrow memory port that can merge new data with stored data instead of overwriting it. Every write reads the addressed word, combines each incoming bit Di with the stored bit Mi through a programmable two-input boolean function, and writes the result back in the same clock cycle. A per-bit mask chooses which bits of the word actually change.

A setup command loads two things at once. The function code comes from the low four bits of the command address, and a persistent mask comes from the command's data levels. Two code values act as controls and do not pick a function. Any single write may also carry a one-shot mask. For that write only, the one-shot mask replaces the persistent mask and the function becomes plain pass-through. A small internal RAM, cleared by reset, stands in for the memory array. It has a registered read port so that stored contents can be observed.

Top module: `rop_write_unit`

## Requirements
- R1: After reset, `uninit` is 1, `logic_on` is 0, `sam_by1` is 0, `rd_data` is 0 and every RAM word reads 0.
- R2: Before the first setup command, a write stores `wr_data` unchanged in all bits, whatever the mask inputs are.
- R3: A setup command takes its code from `cmd_addr[3:0]` and ignores `cmd_addr[7:4]`. It loads the persistent mask from `cmd_mask` and clears `uninit` one cycle later. Any code other than 0011 and 0101 sets `logic_on`.
- R4: In logic mode a write stores f(Di,Mi) bitwise. Code bit 0 gives the result for Di=1,Mi=1, bit 1 for Di=0,Mi=1, bit 2 for Di=1,Mi=0 and bit 3 for Di=0,Mi=0. For example, 0001 is AND, 0110 is XOR and 1110 is NAND.
- R5: A mask bit of 1 lets that bit be written and a mask bit of 0 keeps the old stored bit. The persistent mask stays in force across writes until the next setup command.
- R6: Setup code 0101 clears `logic_on`. Later writes store Di directly, still gated by the persistent mask.
- R7: Setup code 0011 sets `sam_by1`, which stays set until reset. The previous function code and the `logic_on` state are kept, and the mask is still loaded.
- R8: A write with `wr_oneshot` high uses `wr_os_mask` in place of the persistent mask and stores Di pass-through for that write only. The next write returns to the persistent mask and the programmed function.
- R9: When a setup command and a write occur in the same cycle, the setup takes effect and the write is dropped.
- R10: A read returns the addressed word on `rd_data` one cycle later. If a write to the same word happens in that cycle, the read returns the word as it was before that write. `rd_data` holds its value when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_setup | input | 1 | Setup command strobe |
| cmd_addr | input | 8 | Setup address; bits 3:0 are the function code |
| cmd_mask | input | 4 | Persistent mask loaded by setup |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 4 | Write data Di |
| wr_oneshot | input | 1 | Use the one-shot mask for this write |
| wr_os_mask | input | 4 | One-shot mask |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 4 | Registered read data |
| logic_on | output | 1 | Logic function mode active |
| sam_by1 | output | 1 | Serial organisation switched to single-bit width |
| uninit | output | 1 | No setup command seen since reset |

## Verification
The bench sweeps all sixteen codes over one fixed (Di, Mi) pair. A design with reversed truth-table indexing would store wrong words for the asymmetric codes. It also checks that the 0011 control code keeps the old function, since a design that loaded it as a function would produce a different result on the next write. The one-shot write is followed by a plain write, which catches a design that lets the override leak into later cycles or leaves the function active during the override. A setup issued together with a write, and a read issued together with a write to the same word, exercise the two same-cycle orderings. A design that gets these wrong either stores the dropped word or reads back the new value.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef logic [3:0] fcode_t;
  localparam fcode_t FC_THRU  = 4'b0101;
  localparam fcode_t FC_SERX1 = 4'b0011;
endpackage

// File: rtl/rop_cmd_regs.sv
module rop_cmd_regs #(
  parameter int DW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup,
  input  rop_pkg::fcode_t   setup_code,
  input  logic [DW-1:0]     setup_mask,
  output rop_pkg::fcode_t   code_q,
  output logic [DW-1:0]     pmask_q,
  output logic              active_q,
  output logic              by1_q,
  output logic              uninit_q
);
  import rop_pkg::*;

  fcode_t        code_d;
  logic [DW-1:0] pmask_d;
  logic          active_d, by1_d, uninit_d;

  always_comb begin
    code_d   = code_q;
    pmask_d  = pmask_q;
    active_d = active_q;
    by1_d    = by1_q;
    uninit_d = uninit_q;
    if (setup) begin
      pmask_d  = setup_mask;
      uninit_d = 1'b0;
      if (setup_code == FC_SERX1) begin
        by1_d = 1'b1;
      end else if (setup_code == FC_THRU) begin
        code_d   = FC_THRU;
        active_d = 1'b0;
      end else begin
        code_d   = setup_code;
        active_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= FC_THRU;
      pmask_q  <= '1;
      active_q <= 1'b0;
      by1_q    <= 1'b0;
      uninit_q <= 1'b1;
    end else if (setup) begin
      code_q   <= code_d;
      pmask_q  <= pmask_d;
      active_q <= active_d;
      by1_q    <= by1_d;
      uninit_q <= uninit_d;
    end
  end
endmodule

// File: rtl/rop_alu.sv
module rop_alu #(
  parameter int DW = 4
) (
  input  rop_pkg::fcode_t code,
  input  logic [DW-1:0]   di,
  input  logic [DW-1:0]   mi,
  input  logic [DW-1:0]   mask,
  output logic [DW-1:0]   wb
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic [1:0] sel;
    logic       fres;
    always_comb begin
      sel  = {~mi[b], ~di[b]};
      fres = code[sel];
      wb[b] = mask[b] ? fres : mi[b];
    end
  end
endmodule

// File: rtl/rop_mem.sv
module rop_mem #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] old_data,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_comb old_data = mem_q[waddr];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    always_comb hit = we && (waddr == AW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[w] <= '0;
      else if (hit) mem_q[w] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/rop_write_unit.sv
module rop_write_unit #(
  parameter int DW = 4,
  parameter int AW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_setup,
  input  logic [CW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_mask,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_oneshot,
  input  logic [DW-1:0] wr_os_mask,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          logic_on,
  output logic          sam_by1,
  output logic          uninit
);
  import rop_pkg::*;

  fcode_t        code_q, eff_code;
  logic [DW-1:0] pmask_q, eff_mask, old_word, new_word;
  logic          wr_go;

  rop_cmd_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .setup(cmd_setup),
    .setup_code(fcode_t'(cmd_addr[3:0])), .setup_mask(cmd_mask),
    .code_q(code_q), .pmask_q(pmask_q), .active_q(logic_on),
    .by1_q(sam_by1), .uninit_q(uninit)
  );

  always_comb begin
    wr_go    = wr_en && !cmd_setup;
    eff_code = (wr_oneshot || !logic_on) ? FC_THRU : code_q;
    eff_mask = wr_oneshot ? wr_os_mask : pmask_q;
  end

  rop_alu #(.DW(DW)) u_alu (
    .code(eff_code), .di(wr_data), .mi(old_word), .mask(eff_mask), .wb(new_word)
  );

  rop_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_go), .waddr(wr_addr), .wdata(new_word),
    .old_data(old_word), .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/rop_write_unit_chk.sv
module rop_write_unit_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_setup,
  input logic [CW-1:0] cmd_addr,
  input logic          logic_on,
  input logic          sam_by1,
  input logic          uninit
);
  assert_setup_clears_uninit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_setup |=> !uninit);

  assert_uninit_not_logic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uninit |-> !logic_on);

  assert_thru_code_exits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_setup && cmd_addr[3:0] == 4'b0101) |=> !logic_on);

  assert_serx1_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_setup && cmd_addr[3:0] == 4'b0011) |=> sam_by1);

  assert_serx1_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sam_by1 |=> sam_by1);

  assert_serx1_keeps_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_setup && cmd_addr[3:0] == 4'b0011) |=> $stable(logic_on));

  assert_mode_needs_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_setup |=> $stable(logic_on));
endmodule

bind rop_write_unit rop_write_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_setup(cmd_setup), .cmd_addr(cmd_addr),
  .logic_on(logic_on), .sam_by1(sam_by1), .uninit(uninit)
);

// File: tb/rop_write_unit_bench.sv
module rop_write_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_setup = 1'b0;
  logic [7:0] cmd_addr = '0;
  logic [3:0] cmd_mask = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0, wr_data = '0;
  logic       wr_oneshot = 1'b0;
  logic [3:0] wr_os_mask = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic       logic_on, sam_by1, uninit;

  int vectors = 0;
  int errors = 0;

  logic [3:0] m_mem [16];
  logic [3:0] m_code, m_pmask, m_rd;
  logic       m_on, m_by1, m_un;
  string      tag = "R1";

  always #10 clk = ~clk;

  rop_write_unit u_rop_write_unit (
    .clk(clk), .rst_n(rst_n), .cmd_setup(cmd_setup), .cmd_addr(cmd_addr),
    .cmd_mask(cmd_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_oneshot(wr_oneshot), .wr_os_mask(wr_os_mask), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .logic_on(logic_on),
    .sam_by1(sam_by1), .uninit(uninit)
  );

  function automatic logic [3:0] apply_fn(logic [3:0] c, logic [3:0] d, logic [3:0] m);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) begin
      if (d[b] && m[b])        r[b] = c[0];
      else if (!d[b] && m[b])  r[b] = c[1];
      else if (d[b] && !m[b])  r[b] = c[2];
      else                     r[b] = c[3];
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    m_code = 4'b0101; m_pmask = 4'hF; m_rd = '0;
    m_on = 1'b0; m_by1 = 1'b0; m_un = 1'b1;
  endtask

  task automatic model_step();
    logic [3:0] f, mk, res;
    if (rd_en) m_rd = m_mem[rd_addr];
    if (wr_en && !cmd_setup) begin
      f   = (wr_oneshot || !m_on) ? 4'b0101 : m_code;
      mk  = wr_oneshot ? wr_os_mask : m_pmask;
      res = apply_fn(f, wr_data, m_mem[wr_addr]);
      m_mem[wr_addr] = (res & mk) | (m_mem[wr_addr] & ~mk);
    end
    if (cmd_setup) begin
      m_pmask = cmd_mask; m_un = 1'b0;
      if (cmd_addr[3:0] == 4'b0011) m_by1 = 1'b1;
      else if (cmd_addr[3:0] == 4'b0101) begin m_code = 4'b0101; m_on = 1'b0; end
      else begin m_code = cmd_addr[3:0]; m_on = 1'b1; end
    end
  endtask

  task automatic compare();
    vectors++;
    if (rd_data !== m_rd || logic_on !== m_on || sam_by1 !== m_by1 || uninit !== m_un) begin
      errors++;
      $display("FAIL %s: rd=%h on=%b by1=%b un=%b expected rd=%h on=%b by1=%b un=%b",
               tag, rd_data, logic_on, sam_by1, uninit, m_rd, m_on, m_by1, m_un);
    end
  endtask

  task automatic idle_inputs();
    cmd_setup = 0; wr_en = 0; wr_oneshot = 0; rd_en = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  task automatic do_setup(logic [7:0] a, logic [3:0] mk);
    cmd_setup = 1; cmd_addr = a; cmd_mask = mk; tick();
  endtask

  task automatic do_write(logic [3:0] a, logic [3:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick();
  endtask

  task automatic do_os_write(logic [3:0] a, logic [3:0] d, logic [3:0] mk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_oneshot = 1; wr_os_mask = mk; tick();
  endtask

  task automatic do_read(logic [3:0] a);
    rd_en = 1; rd_addr = a; tick();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; compare();
    do_read(4'd0); do_read(4'd9);
    tag = "R2"; cmd_mask = 4'h0;
    do_write(4'd1, 4'hA); do_read(4'd1);
    wr_os_mask = 4'h0; do_write(4'd3, 4'h5); do_read(4'd3);
    tag = "R3"; do_setup(8'hA1, 4'hF);
    tag = "R4"; do_write(4'd1, 4'h6); do_read(4'd1);
    tag = "R5"; do_setup(8'h06, 4'h3);
    do_write(4'd1, 4'hF); do_read(4'd1);
    do_write(4'd1, 4'hF); do_read(4'd1);
    tag = "R8"; do_os_write(4'd1, 4'hF, 4'hC); do_read(4'd1);
    do_write(4'd1, 4'h5); do_read(4'd1);
    tag = "R7"; do_setup(8'h03, 4'hF);
    do_write(4'd1, 4'h9); do_read(4'd1);
    tag = "R6"; do_setup(8'h55, 4'h6);
    do_write(4'd1, 4'h0); do_read(4'd1);
    tag = "R9"; do_setup(8'h07, 4'hF);
    cmd_setup = 1; cmd_addr = 8'h01; cmd_mask = 4'hF;
    wr_en = 1; wr_addr = 4'd4; wr_data = 4'hF; tick();
    do_read(4'd4);
    tag = "R10"; do_write(4'd5, 4'h3);
    wr_en = 1; wr_addr = 4'd5; wr_data = 4'hC; rd_en = 1; rd_addr = 4'd5; tick();
    do_read(4'd5); tick();
    tag = "R4";
    for (int c = 0; c < 16; c++) begin
      do_os_write(4'd2, 4'hC, 4'hF);
      do_setup({4'h0, 4'(c)}, 4'hF);
      do_write(4'd2, 4'hA);
      do_read(4'd2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule